// File: doc/BRIEF.md
# Table-Driven Arbitrary-Order Counter

This block is a 4-bit synchronous counter whose next state comes from a constant lookup table, not from an adder. The current count addresses the table. On each rising clock edge the word the table returns is loaded back into the count register, which is also the block's output. Because each code has its own successor entry, the count can walk through its codes in any order.

Two tables are built in. A one-bit select input chooses which one drives the register on the next edge. The first table walks all sixteen codes in a scrambled order. The second walks a four-code loop. In that loop, every code that does not belong to the cycle points back to the cycle's first state, so a stray value is cleared in one clock.

A synchronous load port sets the count to any code. It serves as a test hook for forcing illegal states.

Top module: `seq_rom_counter`

## Requirements
- R1: While `rst_ni` is low at a rising edge, the count becomes 12 when `seq_sel_i`=0 and 8 when `seq_sel_i`=1. Reset has priority over the load hook and over the table.
- R2: With `seq_sel_i`=0 the count steps 12, 13, 14, 15, 5, 6, 7, 0, 1, 2, 3, 4, 11, 10, 9, 8 and then returns to 12. It advances one entry per edge.
- R3: With `seq_sel_i`=1 the count steps 8, 9, 0, 1 and then returns to 8. It advances one entry per edge.
- R4: With `seq_sel_i`=1, any code from 2 to 7 or from 10 to 15 is followed by 8 on the next edge.
- R5: The `seq_sel_i`=0 table is a single 16-state cycle. Every code, including one forced in by the load hook, has the R2 successor, and no code repeats within a period.
- R6: A change of `seq_sel_i` takes effect on the very next edge. The successor of the present count is taken from the newly selected table.
- R7: When `load_en_i` is high at an edge with `rst_ni` high, the count becomes `load_val_i`. This overrides the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous reset, active low |
| seq_sel_i | input | 1 | Table select: 0 = sixteen-state cycle, 1 = four-state cycle |
| load_en_i | input | 1 | Test hook: force the count on the next edge |
| load_val_i | input | 4 | Test hook: value to force |
| count_o | output | 4 | Count register |

## Verification
The assertions assume that `seq_sel_i`, `load_en_i` and `load_val_i` are stable at each rising edge. They judge each step only from the cycle in which it was launched, so each property excludes cycles in which the load hook or reset was active. The stimulus drives every input on the falling edge, one full half-period before the sampling edge. It changes the select only between steps, which covers switching the table from inside either cycle. It uses the load hook to place the count on each code in turn, so the assertions see every recovery entry.

// File: rtl/seq_rom_pkg.sv
package seq_rom_pkg;
  localparam int unsigned CW     = 4;
  localparam int unsigned NCODES = 1 << CW;

  typedef logic [CW-1:0] code_t;

  typedef enum logic {
    SEQ_A = 1'b0,
    SEQ_B = 1'b1
  } seq_sel_e;

  localparam code_t A_START = code_t'(12);
  localparam code_t B_START = code_t'(8);

  // full 16-state permutation
  function automatic code_t a_succ(code_t c);
    code_t n;
    case (c)
      4'd12:   n = 4'd13;
      4'd13:   n = 4'd14;
      4'd14:   n = 4'd15;
      4'd15:   n = 4'd5;
      4'd5:    n = 4'd6;
      4'd6:    n = 4'd7;
      4'd7:    n = 4'd0;
      4'd0:    n = 4'd1;
      4'd1:    n = 4'd2;
      4'd2:    n = 4'd3;
      4'd3:    n = 4'd4;
      4'd4:    n = 4'd11;
      4'd11:   n = 4'd10;
      4'd10:   n = 4'd9;
      4'd9:    n = 4'd8;
      default: n = 4'd12;  // 8
    endcase
    return n;
  endfunction

  // four-state loop, unused codes fold to start
  function automatic code_t b_succ(code_t c);
    code_t n;
    case (c)
      4'd8:    n = 4'd9;
      4'd9:    n = 4'd0;
      4'd0:    n = 4'd1;
      default: n = B_START;  // 1 and all unused codes
    endcase
    return n;
  endfunction

  function automatic code_t start_of(seq_sel_e s);
    return (s == SEQ_B) ? B_START : A_START;
  endfunction
endpackage

// File: rtl/seq_rom_bank.sv
module seq_rom_bank
  import seq_rom_pkg::*;
#(
  parameter seq_sel_e SEQ = SEQ_A
) (
  input  code_t addr_i,
  output code_t data_o
);
  code_t rom [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_entry
    if (SEQ == SEQ_B) begin : g_b
      assign rom[g] = b_succ(code_t'(g));
    end else begin : g_a
      assign rom[g] = a_succ(code_t'(g));
    end
  end

  assign data_o = rom[addr_i];
endmodule

// File: rtl/seq_next_sel.sv
module seq_next_sel
  import seq_rom_pkg::*;
(
  input  code_t    cur_i,
  input  seq_sel_e sel_i,
  output code_t    nxt_o
);
  code_t nxt_a, nxt_b;

  seq_rom_bank #(.SEQ(SEQ_A)) bank_a_i (.addr_i(cur_i), .data_o(nxt_a));
  seq_rom_bank #(.SEQ(SEQ_B)) bank_b_i (.addr_i(cur_i), .data_o(nxt_b));

  assign nxt_o = (sel_i == SEQ_B) ? nxt_b : nxt_a;
endmodule

// File: rtl/seq_state_reg.sv
module seq_state_reg
  import seq_rom_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  seq_sel_e sel_i,
  input  logic     load_en_i,
  input  code_t    load_val_i,
  input  code_t    nxt_i,
  output code_t    q_o
);
  code_t q_d, q_q;

  always_comb begin
    if (!rst_ni)        q_d = start_of(sel_i);
    else if (load_en_i) q_d = load_val_i;
    else                q_d = nxt_i;
  end

  always_ff @(posedge clk_i) q_q <= q_d;

  assign q_o = q_q;
endmodule

// File: rtl/seq_rom_counter.sv
module seq_rom_counter
  import seq_rom_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       seq_sel_i,
  input  logic       load_en_i,
  input  logic [3:0] load_val_i,
  output logic [3:0] count_o
);
  seq_sel_e sel;
  code_t    cur, nxt;

  assign sel = seq_sel_e'(seq_sel_i);

  seq_next_sel next_i (
    .cur_i(cur),
    .sel_i(sel),
    .nxt_o(nxt)
  );

  seq_state_reg reg_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .load_en_i (load_en_i),
    .load_val_i(load_val_i),
    .nxt_i     (nxt),
    .q_o       (cur)
  );

  assign count_o = cur;

  AST_A_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seq_sel_i && !load_en_i && count_o == 4'd15) |=> count_o == 4'd5); // R2
  AST_A_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seq_sel_i && !load_en_i) |=> count_o != $past(count_o)); // R5
  AST_B_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_sel_i && !load_en_i && count_o inside {4'd0, 4'd1, 4'd8, 4'd9})
    |=> count_o inside {4'd0, 4'd1, 4'd8, 4'd9}); // R3
  AST_B_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_sel_i && !load_en_i && !(count_o inside {4'd0, 4'd1, 4'd8, 4'd9}))
    |=> count_o == 4'd8); // R4
  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> count_o == $past(load_val_i)); // R7
endmodule

// File: tb/seq_rom_counter_tb_top.sv
`timescale 1ns/1ps
module seq_rom_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic       ld = 1'b0;
  logic [3:0] ld_val = '0;
  logic [3:0] cnt;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int    exp_q [$];
  string tag_q [$];
  logic [3:0] model = '0;

  always #5 clk = ~clk;

  seq_rom_counter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .seq_sel_i(sel),
    .load_en_i(ld), .load_val_i(ld_val), .count_o(cnt)
  );

  // ordering lists taken from the requirements
  int ord_a [16] = '{12, 13, 14, 15, 5, 6, 7, 0, 1, 2, 3, 4, 11, 10, 9, 8};
  int ord_b [4]  = '{8, 9, 0, 1};

  function automatic logic [3:0] succ(logic s, logic [3:0] c);
    if (!s) begin
      for (int i = 0; i < 16; i++)
        if (ord_a[i] == int'(c)) return 4'(ord_a[(i + 1) % 16]);
    end else begin
      for (int i = 0; i < 4; i++)
        if (ord_b[i] == int'(c)) return 4'(ord_b[(i + 1) % 4]);
    end
    return 4'd8;
  endfunction

  // driver: drive at falling edge, push expected value after next rising edge
  task automatic step(input logic r, input logic s, input logic l,
                      input logic [3:0] v, input string tag);
    logic [3:0] e;
    @(negedge clk);
    rst_n = r; sel = s; ld = l; ld_val = v;
    if (!r)     e = s ? 4'd8 : 4'd12;
    else if (l) e = v;
    else        e = succ(s, model);
    model = e;
    exp_q.push_back(int'(e));
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (int'(cnt) != e) begin
        bad++;
        $display("FAIL %s: count=%0d expected=%0d", t, cnt, e);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: hung run, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit seen [16];
    // R1 reset values and priority
    step(0, 0, 0, 0, "R1");
    step(0, 1, 0, 0, "R1");
    step(0, 0, 1, 4'd3, "R1");   // reset beats load
    step(0, 0, 0, 0, "R1");
    // R2 two full periods of the 16-state cycle
    for (int i = 0; i < 32; i++) begin
      step(1, 0, 0, 0, "R2");
      if (i < 16) seen[model] = 1;
    end
    begin
      int n = 0;
      foreach (seen[k]) if (seen[k]) n++;
      total++;
      if (n != 16) begin
        bad++;
        $display("FAIL R5: distinct=%0d expected=16", n);
      end
    end
    // R3 two periods of the 4-state loop
    step(0, 1, 0, 0, "R1");
    for (int i = 0; i < 8; i++) step(1, 1, 0, 0, "R3");
    // R4 / R7 force each code, check one-clock recovery in loop B
    for (int c = 0; c < 16; c++) begin
      step(1, 1, 1, 4'(c), "R7");
      step(1, 1, 0, 0, "R4");
    end
    // R5 force each code, check successor in cycle A
    for (int c = 0; c < 16; c++) begin
      step(1, 0, 1, 4'(c), "R7");
      step(1, 0, 0, 0, "R5");
    end
    // R6 switch select mid-run
    step(1, 0, 1, 4'd13, "R7");
    step(1, 1, 0, 0, "R6");        // 13 unused in B -> 8
    step(1, 1, 0, 0, "R6");        // 9
    step(1, 0, 0, 0, "R6");        // A: 9 -> 8
    step(1, 0, 0, 0, "R6");        // 12
    step(1, 1, 1, 4'd0, "R7");
    step(1, 0, 0, 0, "R6");        // A: 0 -> 1
    step(1, 1, 0, 0, "R6");        // B: 1 -> 8
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule